// File: doc/BRIEF.md
# UART Cascaded Baud Rate Generator

This block turns one machine clock into the timing enables that a UART needs. It uses a chain of four counters. A selectable prescaler divides the clock by 6, 4, 3 or 5. A power-of-two stage, set by an exponent field `m`, then divides that result by 2^(m-1), which gives the bit rate for synchronous transfer. A ratio stage divides the synchronous rate by 13 or 12 to give an 8x oversampling tick. A last stage divides that tick by 8 to give the bit tick for asynchronous transfer.

Every output is an enable pulse one clock wide in the machine clock domain. The block makes no derived clocks. The `m` values 0 and 1 are illegal: with either of them the block raises a flag and holds every tick low. The six legal values of `m` and the two ratio choices give twelve asynchronous rates.

Any change to a select input clears the whole chain. The shifter that uses the ticks therefore always sees a complete period in the new setting first.

Top module: `uart_baud_cascade`

## Requirements
- R1: The 2-bit `preSel` sets the prescaler ratio: 2'b00 selects 6, 2'b01 selects 4, 2'b10 selects 3 and 2'b11 selects 5. With P as that ratio and D = 2^(m-1), `syncTick` pulses once every P*D clocks.
- R2: The 3-bit `expM` gives the exponent m, which sets D = 2^(m-1) for every m from 2 to 7.
- R3: When `expM` is 0 or 1, `badSetting` is high for as long as that value stays on the input, and `syncTick`, `sampleTick` and `bitTick` all stay low. For every other value, `badSetting` is low.
- R4: `sampleTick` pulses once every 13 `syncTick` pulses when `ratioSel` is 0, and once every 12 when `ratioSel` is 1. It coincides with the last of those `syncTick` pulses.
- R5: `bitTick` pulses once every 8 `sampleTick` pulses and coincides with the eighth.
- R6: Each tick is high for one clock only. `bitTick` is high only in a cycle where `sampleTick` is high, and `sampleTick` is high only in a cycle where `syncTick` is high.
- R7: In the cycle where any select input differs from its value in the previous cycle, no tick is issued. Counting then restarts from zero in the next cycle, so the first `syncTick` comes P*D clocks after the change.
- R8: While `rst` is high, no tick is issued. In the first cycle after `rst` falls, all counters are at zero, so the first `syncTick` comes in the (P*D)-th cycle after that point, with that cycle counted as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| preSel | input | 2 | Prescaler select (6, 4, 3, 5) |
| expM | input | 3 | Exponent m of the power-of-two stage |
| ratioSel | input | 1 | Ratio stage select: 0 divides by 13, 1 divides by 12 |
| syncTick | output | 1 | Bit-rate enable for synchronous mode |
| sampleTick | output | 1 | 8x oversampling enable for asynchronous mode |
| bitTick | output | 1 | Bit-rate enable for asynchronous mode |
| badSetting | output | 1 | High while `expM` holds an illegal value |

## Verification
The bench predicts the exact cycle of every tick for several settings. These cover all four prescaler codes, the smallest and largest exponents, and both ratio choices, so a swapped prescaler code, an exponent off by one or a swapped 13/12 shows up as a tick in the wrong cycle.

It switches settings in the middle of a period and asserts reset while the counters are running. A design that kept stale counts, or that let a tick through in the cycle of the change, would put its first tick early.

It also steps through `m` = 1 and `m` = 0. A design that treated these as a slow rate would produce ticks, and one that dropped the flag would show `badSetting` low.

// File: rtl/baud_cascade_pkg.sv
package baud_cascade_pkg;

  localparam int PRE_W = 3;

  typedef struct packed {
    logic clr;
    logic run;
  } strobe_t;

  // Terminal count of the prescaler for each select code.
  function automatic logic [PRE_W-1:0] prescaleLast(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRE_W'(5);
      2'b01:   return PRE_W'(3);
      2'b10:   return PRE_W'(2);
      default: return PRE_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/baud_cascade_stage.sv
module baud_cascade_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last,
  output logic         wrap
);

  logic [W-1:0] cnt;

  assign wrap = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (clr)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (en)   cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/baud_cascade_ctrl.sv
module baud_cascade_ctrl
  import baud_cascade_pkg::*;
#(
  parameter int EXP_W     = 3,
  parameter int POW_W     = 6,
  parameter int RAT_W     = 4,
  parameter int RATIO_ZERO = 13,
  parameter int RATIO_ONE  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       preSel,
  input  logic [EXP_W-1:0] expM,
  input  logic             ratioSel,
  output strobe_t          strb,
  output logic [PRE_W-1:0] preLast,
  output logic [POW_W-1:0] powLast,
  output logic [RAT_W-1:0] ratLast,
  output logic             badSetting
);

  localparam int SEL_W = 2 + EXP_W + 1;

  logic [SEL_W-1:0] selNow;
  logic [SEL_W-1:0] selPrev;
  logic             selChanged;
  logic [POW_W:0]   powSpan;

  assign selNow     = {preSel, expM, ratioSel};
  assign selChanged = (selNow != selPrev);
  assign badSetting = (expM < EXP_W'(2));

  // Tracks the select inputs each cycle; loaded during reset too, so release is clean.
  always_ff @(posedge clk) begin
    selPrev <= selNow;
  end

  always_comb begin
    strb.clr = rst || selChanged || badSetting;
    strb.run = !strb.clr;
  end

  assign preLast = prescaleLast(preSel);
  assign powSpan = (POW_W+1)'(1) << (expM - EXP_W'(1));
  assign powLast = badSetting ? '0 : POW_W'(powSpan - (POW_W+1)'(1));
  assign ratLast = ratioSel ? RAT_W'(RATIO_ONE - 1) : RAT_W'(RATIO_ZERO - 1);

endmodule

// File: rtl/baud_cascade_dp.sv
module baud_cascade_dp
  import baud_cascade_pkg::*;
#(
  parameter int POW_W      = 6,
  parameter int RAT_W      = 4,
  parameter int OVERSAMPLE = 8
) (
  input  logic             clk,
  input  strobe_t          strb,
  input  logic [PRE_W-1:0] preLast,
  input  logic [POW_W-1:0] powLast,
  input  logic [RAT_W-1:0] ratLast,
  output logic             syncTick,
  output logic             sampleTick,
  output logic             bitTick
);

  localparam int OVS_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;

  logic preWrap;
  logic powWrap;
  logic ratWrap;
  logic ovsWrap;

  baud_cascade_stage #(.W(PRE_W)) u_pre (
    .clk(clk), .clr(strb.clr), .en(strb.run), .last(preLast), .wrap(preWrap));

  baud_cascade_stage #(.W(POW_W)) u_pow (
    .clk(clk), .clr(strb.clr), .en(preWrap), .last(powLast), .wrap(powWrap));

  baud_cascade_stage #(.W(RAT_W)) u_rat (
    .clk(clk), .clr(strb.clr), .en(powWrap), .last(ratLast), .wrap(ratWrap));

  baud_cascade_stage #(.W(OVS_W)) u_ovs (
    .clk(clk), .clr(strb.clr), .en(ratWrap), .last(OVS_W'(OVERSAMPLE - 1)), .wrap(ovsWrap));

  assign syncTick   = powWrap;
  assign sampleTick = ratWrap;
  assign bitTick    = ovsWrap;

endmodule

// File: rtl/uart_baud_cascade.sv
module uart_baud_cascade
  import baud_cascade_pkg::*;
#(
  parameter int EXP_W      = 3,
  parameter int RATIO_ZERO = 13,
  parameter int RATIO_ONE  = 12,
  parameter int OVERSAMPLE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       preSel,
  input  logic [EXP_W-1:0] expM,
  input  logic             ratioSel,
  output logic             syncTick,
  output logic             sampleTick,
  output logic             bitTick,
  output logic             badSetting
);

  localparam int POW_W   = (1 << EXP_W) - 2;
  localparam int RAT_MAX = (RATIO_ZERO > RATIO_ONE) ? RATIO_ZERO : RATIO_ONE;
  localparam int RAT_W   = $clog2(RAT_MAX);

  strobe_t          strb;
  logic [PRE_W-1:0] preLast;
  logic [POW_W-1:0] powLast;
  logic [RAT_W-1:0] ratLast;

  baud_cascade_ctrl #(
    .EXP_W(EXP_W), .POW_W(POW_W), .RAT_W(RAT_W),
    .RATIO_ZERO(RATIO_ZERO), .RATIO_ONE(RATIO_ONE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .preSel(preSel), .expM(expM), .ratioSel(ratioSel),
    .strb(strb), .preLast(preLast), .powLast(powLast), .ratLast(ratLast),
    .badSetting(badSetting));

  baud_cascade_dp #(
    .POW_W(POW_W), .RAT_W(RAT_W), .OVERSAMPLE(OVERSAMPLE)
  ) u_dp (
    .clk(clk), .strb(strb), .preLast(preLast), .powLast(powLast), .ratLast(ratLast),
    .syncTick(syncTick), .sampleTick(sampleTick), .bitTick(bitTick));

endmodule

// File: rtl/uart_baud_cascade_chk.sv
module uart_baud_cascade_chk #(
  parameter int EXP_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       preSel,
  input logic [EXP_W-1:0] expM,
  input logic             ratioSel,
  input logic             syncTick,
  input logic             sampleTick,
  input logic             bitTick,
  input logic             badSetting
);

  // R6
  bit_in_sample_chk: assert property (@(posedge clk) disable iff (rst)
    bitTick |-> sampleTick);

  // R6
  sample_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    sampleTick |-> syncTick);

  // R6
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    syncTick |=> !syncTick);

  // R3
  bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (expM < EXP_W'(2)) |-> (badSetting && !syncTick && !sampleTick && !bitTick));

  // R3
  good_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (expM >= EXP_W'(2)) |-> !badSetting);

  // R7
  change_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ({preSel, expM, ratioSel} != $past({preSel, expM, ratioSel})) |-> !syncTick);

  // R8
  always @(posedge clk) begin
    if (rst === 1'b1) begin
      rst_quiet_chk: assert (!syncTick && !sampleTick && !bitTick);
    end
  end

endmodule

bind uart_baud_cascade uart_baud_cascade_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .preSel(preSel), .expM(expM), .ratioSel(ratioSel),
  .syncTick(syncTick), .sampleTick(sampleTick), .bitTick(bitTick),
  .badSetting(badSetting));

// File: tb/uart_baud_cascade_tb_top.sv
module uart_baud_cascade_tb_top;

  typedef struct {
    int unsigned cyc;
    logic [2:0]  mask;   // {bitTick, sampleTick, syncTick}
  } ev_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] preSel = 2'b00;
  logic [2:0] expM = 3'd2;
  logic       ratioSel = 1'b0;
  logic       syncTick, sampleTick, bitTick, badSetting;

  int unsigned cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic        expBad = 1'b0;
  string       curReq = "R8";
  ev_t         evQ[$];

  uart_baud_cascade dut_i (
    .clk(clk), .rst(rst), .preSel(preSel), .expM(expM), .ratioSel(ratioSel),
    .syncTick(syncTick), .sampleTick(sampleTick), .bitTick(bitTick),
    .badSetting(badSetting));

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int preRatio(input logic [1:0] s);
    case (s)
      2'b00: return 6;
      2'b01: return 4;
      2'b10: return 3;
      default: return 5;
    endcase
  endfunction

  // Driver side: predict every tick in [base, stop) with counters zero at base.
  task automatic pushExpect(input int unsigned base, input int unsigned stop,
                            input logic [1:0] p, input logic [2:0] m, input logic r);
    int pd, pr, pb;
    if (m < 3'd2) return;
    pd = preRatio(p) * (1 << (m - 1));
    pr = pd * (r ? 12 : 13);
    pb = pr * 8;
    for (int unsigned t = base; t < stop; t++) begin
      int k;
      ev_t e;
      k = int'(t - base) + 1;
      e.cyc  = t;
      e.mask = {(k % pb) == 0, (k % pr) == 0, (k % pd) == 0};
      if (e.mask != 3'b000) evQ.push_back(e);
    end
  endtask

  task automatic applyCase(input logic [1:0] p, input logic [2:0] m, input logic r,
                           input int n, input string tag);
    int unsigned c;
    @(posedge clk); #1;
    preSel = p; expM = m; ratioSel = r;
    expBad = (m < 3'd2);
    curReq = tag;
    c = cyc;
    pushExpect(c + 1, c + n, p, m, r);
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic resetCase(input logic [1:0] p, input logic [2:0] m, input logic r,
                           input int hold, input int n, input string tag);
    int unsigned rr;
    @(posedge clk); #1;
    rst = 1'b1;
    preSel = p; expM = m; ratioSel = r;
    expBad = (m < 3'd2);
    curReq = "R8";
    repeat (hold) @(posedge clk);
    #1;
    rst = 1'b0;
    curReq = tag;
    rr = cyc;
    pushExpect(rr, rr + n, p, m, r);
    repeat (n - 1) @(posedge clk);
  endtask

  // Monitor side: pop the prediction for this cycle and compare.
  always @(negedge clk) begin
    logic [2:0] expMask;
    logic [2:0] obsMask;
    expMask = 3'b000;
    if (evQ.size() > 0 && evQ[0].cyc < cyc) begin
      fails++;
      $display("FAIL %s: stale prediction for cycle %0d, actual none expected %b",
               curReq, evQ[0].cyc, evQ[0].mask);
      void'(evQ.pop_front());
    end
    if (evQ.size() > 0 && evQ[0].cyc == cyc) expMask = evQ.pop_front().mask;
    obsMask = {bitTick, sampleTick, syncTick};
    checks++;
    if (obsMask !== expMask) begin
      fails++;
      $display("FAIL %s R6: cycle %0d ticks {bit,sample,sync} actual %b expected %b",
               curReq, cyc, obsMask, expMask);
    end
    checks++;
    if (badSetting !== expBad) begin
      fails++;
      $display("FAIL R3: cycle %0d badSetting actual %b expected %b",
               cyc, badSetting, expBad);
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    // R8 release from reset; R1 /6, R4 ratio 13, R5 one bit tick at 1248
    resetCase(2'b00, 3'd2, 1'b0, 3, 1300, "R8 R1 R4 R5");
    // R7 restart; R1 /4, R2 m=3, R4 ratio 12, R5 bit tick at 1536
    applyCase(2'b01, 3'd3, 1'b1, 1600, "R7 R1 R2 R4 R5");
    // R2 largest exponent m=7 with /3
    applyCase(2'b10, 3'd7, 1'b0, 500, "R2 R1");
    // R1 /5 with m=4, ratio 12
    applyCase(2'b11, 3'd4, 1'b1, 1000, "R1 R2 R4");
    // R3 illegal exponents
    applyCase(2'b11, 3'd1, 1'b1, 200, "R3");
    applyCase(2'b11, 3'd0, 1'b1, 100, "R3");
    // R7 recovery from illegal, then a change mid-period
    applyCase(2'b10, 3'd2, 1'b1, 1200, "R7 R5");
    applyCase(2'b10, 3'd2, 1'b0, 50, "R7 R4");
    applyCase(2'b10, 3'd2, 1'b1, 600, "R7 R5");
    // R8 reset while running
    resetCase(2'b00, 3'd5, 1'b0, 3, 300, "R8 R2");
    @(posedge clk);
    #1;
    checks++;
    if (evQ.size() != 0) begin
      fails++;
      $display("FAIL R6: unconsumed predictions actual %0d expected 0", evQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule